// File: doc/BRIEF.md
# Instruction Prefetch Buffer with Flush

This block sits between the instruction fetch port and the instruction decoder of a script processor. It requests dwords at consecutive addresses, holds up to eight of them in a small queue, and gives them to the decoder one at a time, in address order. When the decoder asks for a dword and the queue is empty, the request stalls. Nothing is returned in that case.

Some events make the queued dwords stale:
- a write to the script pointer;
- a transfer-control instruction whose condition is met;
- a store that lacks the no-flush qualifier;
- a software flush bit, which clears itself.

Any of these events empties the queue in a single cycle and restarts fetching at the correct address. Dwords that were already requested before the flush still come back. The block drops them.

The fetch side does not use address tags. Responses arrive in order, one for each accepted request. The block keeps a count of outstanding requests and a count of stale responses still to be dropped. Only responses that arrive once the drop count is zero enter the queue.

Top module: `instr_prefetch_buf`

## Requirements
- R1: After reset, `instr_valid`, `refetch` and `ctl_flush_bit` are 0, `fetch_req` is 1 and `fetch_addr` equals `RESET_ADDR` (0).
- R2: Each accepted fetch advances `fetch_addr` by 4. Successive decoder pops return the dwords of consecutive addresses, in order.
- R3: The number of queued dwords plus the number of outstanding fetches never exceeds `DEPTH` (8). `fetch_req` is 0 while that sum equals `DEPTH`, and a full queue delivers 8 dwords on 8 back-to-back pops.
- R4: A write to the script pointer (`sp_wr`) flushes the queue. On the next cycle `instr_valid` is 0, `refetch` is 1 and `fetch_addr` equals `sp_wdata`.
- R5: A transfer instruction with `xfer_done=1` and `xfer_hit=1` flushes the queue and restarts at `xfer_target`. With `xfer_hit=0` the queue contents and their order are unchanged and no refetch occurs.
- R6: A store (`store_done=1`) flushes the queue and restarts at the address of the next undelivered dword, unless `store_noflush=1`. In that case nothing changes.
- R7: A write of the software flush control (`ctl_flush_wr`) sets `ctl_flush_bit` for exactly one cycle. The flush happens on the following edge and the bit then reads 0 again.
- R8: Flush causes that occur in the same cycle merge into one flush with a single one-cycle `refetch` pulse. The restart address is chosen by priority: script-pointer write first, then taken-transfer target, then the next undelivered address.
- R9: Responses to fetches issued before a flush, including one issued in the flush cycle itself, are dropped. They never reach `instr_data`.
- R10: `instr_pop` while `instr_valid` is 0 is ignored. The next dword delivered is still the one at the restart address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | output | 1 | Fetch request; a room exists for one more dword |
| fetch_addr | output | AW | Byte address of the requested dword |
| fetch_ack | input | 1 | Request accepted this cycle |
| rsp_valid | input | 1 | A fetched dword returns this cycle (in request order) |
| rsp_data | input | DW | Returned dword |
| instr_pop | input | 1 | Decoder takes the dword shown on `instr_data` |
| instr_valid | output | 1 | `instr_data` holds a valid dword |
| instr_data | output | DW | Oldest queued dword |
| sp_wr | input | 1 | Script pointer write strobe |
| sp_wdata | input | AW | Value written to the script pointer |
| xfer_done | input | 1 | Transfer-control instruction executed |
| xfer_hit | input | 1 | Its condition was met |
| xfer_target | input | AW | Transfer destination address |
| store_done | input | 1 | Store instruction executed |
| store_noflush | input | 1 | Store carries the no-flush qualifier |
| ctl_flush_wr | input | 1 | Software writes 1 to the flush control bit |
| ctl_flush_bit | output | 1 | Readback of the self-clearing flush bit |
| refetch | output | 1 | One-cycle pulse: fetching restarts at `fetch_addr` |

## Verification
The assertions rely on these assumptions about the inputs:
- The fetch port returns responses strictly in request order.
- It never returns more responses than there are outstanding requests.
- Every event strobe lasts one cycle.

The bench meets these assumptions with a fixed two-stage response pipeline that is loaded only on an accepted request. Its strobes are driven on the falling edge and held for exactly one cycle. The drop counter is therefore never asked to drop a response that was never requested. The bench derives each returned dword from its address, so an out-of-order or stale dword shows up as a data mismatch.

// File: rtl/instr_prefetch_buf.sv
module instr_prefetch_buf #(
  parameter int DEPTH      = 8,
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_ack,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  input  logic          instr_pop,
  output logic          instr_valid,
  output logic [DW-1:0] instr_data,
  input  logic          sp_wr,
  input  logic [AW-1:0] sp_wdata,
  input  logic          xfer_done,
  input  logic          xfer_hit,
  input  logic [AW-1:0] xfer_target,
  input  logic          store_done,
  input  logic          store_noflush,
  input  logic          ctl_flush_wr,
  output logic          ctl_flush_bit,
  output logic          refetch
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;
  localparam logic [CW:0]   DEPTH_W = (CW+1)'(DEPTH);
  localparam logic [AW-1:0] STEP    = AW'(4);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, inflight, drop;
  logic [AW-1:0] head_addr;
  logic          sw_flush_q;

  wire issue       = fetch_req && fetch_ack;
  wire xfer_flush  = xfer_done && xfer_hit;
  wire store_flush = store_done && !store_noflush;
  wire flush_now   = sp_wr || xfer_flush || store_flush || sw_flush_q;
  wire pop         = instr_pop && instr_valid;
  wire accept      = rsp_valid && (drop == '0) && !flush_now;

  wire [CW:0]    occupancy  = {1'b0, count} + {1'b0, inflight};
  wire [CW-1:0]  inflight_n = inflight + CW'(issue) - CW'(rsp_valid);
  wire [AW-1:0]  next_head  = pop ? head_addr + STEP : head_addr;
  wire [AW-1:0]  restart    = sp_wr      ? sp_wdata :
                              xfer_flush ? xfer_target : next_head;

  assign fetch_req     = occupancy < DEPTH_W;
  assign instr_valid   = count != '0;
  assign instr_data    = mem[rd_ptr];
  assign ctl_flush_bit = sw_flush_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count      <= '0;
      inflight   <= '0;
      drop       <= '0;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      fetch_addr <= RESET_ADDR;
      head_addr  <= RESET_ADDR;
      sw_flush_q <= 1'b0;
      refetch    <= 1'b0;
    end else begin
      inflight   <= inflight_n;
      sw_flush_q <= ctl_flush_wr;
      refetch    <= flush_now;
      if (flush_now) begin
        count      <= '0;
        wr_ptr     <= '0;
        rd_ptr     <= '0;
        drop       <= inflight_n;
        fetch_addr <= restart;
        head_addr  <= restart;
      end else begin
        count     <= count + CW'(accept) - CW'(pop);
        head_addr <= next_head;
        if (issue)  fetch_addr <= fetch_addr + STEP;
        if (pop)    rd_ptr <= rd_ptr + PW'(1);
        if (accept) wr_ptr <= wr_ptr + PW'(1);
        if (rsp_valid && drop != '0) drop <= drop - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= rsp_data;
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= DEPTH_W);

  p_seq_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !flush_now) |=> fetch_addr == $past(fetch_addr) + STEP);

  p_flush_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_now |=> (!instr_valid && refetch));

  p_sp_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr |=> fetch_addr == $past(sp_wdata));

  p_xfer_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_flush && !sp_wr) |=> fetch_addr == $past(xfer_target));

  p_swbit_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_flush_bit && !ctl_flush_wr) |=> !ctl_flush_bit);

  p_drop_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop <= inflight);

  p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_pop && !instr_valid && !flush_now) |=> $stable(head_addr));
endmodule

// File: tb/instr_prefetch_buf_tb.sv
`timescale 1ns/1ps
module instr_prefetch_buf_tb;
  localparam int AW = 32;
  localparam int DW = 32;

  localparam logic [2:0] OP_POP   = 3'd0;
  localparam logic [2:0] OP_SPWR  = 3'd1;
  localparam logic [2:0] OP_XHIT  = 3'd2;
  localparam logic [2:0] OP_XMISS = 3'd3;
  localparam logic [2:0] OP_STF   = 3'd4;
  localparam logic [2:0] OP_STNF  = 3'd5;
  localparam logic [2:0] OP_SWF   = 3'd6;
  localparam logic [2:0] OP_IDLE  = 3'd7;

  localparam int NV = 14;
  localparam logic [34:0] TBL [NV] = '{
    {OP_POP,   32'd5},
    {OP_SPWR,  32'h0000_0200},
    {OP_POP,   32'd3},
    {OP_IDLE,  32'd12},
    {OP_XMISS, 32'h0000_0800},
    {OP_POP,   32'd2},
    {OP_XHIT,  32'h0000_0800},
    {OP_POP,   32'd4},
    {OP_IDLE,  32'd12},
    {OP_STNF,  32'd0},
    {OP_POP,   32'd2},
    {OP_STF,   32'd0},
    {OP_POP,   32'd3},
    {OP_SWF,   32'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          fetch_req, fetch_ack, rsp_valid, instr_pop, instr_valid;
  logic [AW-1:0] fetch_addr, sp_wdata, xfer_target;
  logic [DW-1:0] rsp_data, instr_data;
  logic          sp_wr, xfer_done, xfer_hit, store_done, store_noflush;
  logic          ctl_flush_wr, ctl_flush_bit, refetch;

  instr_prefetch_buf u_dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .instr_pop(instr_pop), .instr_valid(instr_valid), .instr_data(instr_data),
    .sp_wr(sp_wr), .sp_wdata(sp_wdata),
    .xfer_done(xfer_done), .xfer_hit(xfer_hit), .xfer_target(xfer_target),
    .store_done(store_done), .store_noflush(store_noflush),
    .ctl_flush_wr(ctl_flush_wr), .ctl_flush_bit(ctl_flush_bit),
    .refetch(refetch)
  );

  function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0]};
  endfunction

  logic          pv0, pv1;
  logic [AW-1:0] pa0, pa1;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv0 <= 1'b0; pv1 <= 1'b0; pa0 <= '0; pa1 <= '0;
    end else begin
      pv0 <= fetch_req && fetch_ack;
      pa0 <= fetch_addr;
      pv1 <= pv0;
      pa1 <= pa0;
    end
  end
  assign rsp_valid = pv1;
  assign rsp_data  = memval(pa1);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [AW-1:0] exp_addr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pop_one(input string req);
    int w = 0;
    while (!instr_valid && w < 60) begin @(negedge clk); w++; end
    chk(req, instr_data, memval(exp_addr));
    instr_pop = 1'b1;
    @(negedge clk);
    instr_pop = 1'b0;
    exp_addr = exp_addr + 4;
  endtask

  task automatic after_flush(input string req, input logic [AW-1:0] a);
    chk({req, " valid"}, 32'(instr_valid), 32'd0);
    chk({req, " refetch"}, 32'(refetch), 32'd1);
    chk({req, " addr"}, fetch_addr, a);
    exp_addr = a;
    @(negedge clk);
    chk("R8 single pulse", 32'(refetch), 32'd0);
  endtask

  task automatic run_op(input logic [2:0] op, input logic [31:0] arg);
    case (op)
      OP_POP:  for (int i = 0; i < int'(arg); i++) pop_one("R2 order");
      OP_IDLE: repeat (int'(arg)) @(negedge clk);
      OP_SPWR: begin
        sp_wr = 1'b1; sp_wdata = arg; @(negedge clk); sp_wr = 1'b0;
        after_flush("R4 sp write", arg);
      end
      OP_XHIT: begin
        xfer_done = 1'b1; xfer_hit = 1'b1; xfer_target = arg;
        @(negedge clk); xfer_done = 1'b0; xfer_hit = 1'b0;
        after_flush("R5 taken", arg);
      end
      OP_XMISS: begin
        xfer_done = 1'b1; xfer_hit = 1'b0; xfer_target = arg;
        @(negedge clk); xfer_done = 1'b0;
        chk("R5 not taken refetch", 32'(refetch), 32'd0);
        chk("R5 not taken valid", 32'(instr_valid), 32'd1);
        chk("R5 not taken data", instr_data, memval(exp_addr));
      end
      OP_STNF: begin
        store_done = 1'b1; store_noflush = 1'b1;
        @(negedge clk); store_done = 1'b0; store_noflush = 1'b0;
        chk("R6 noflush refetch", 32'(refetch), 32'd0);
        chk("R6 noflush data", instr_data, memval(exp_addr));
      end
      OP_STF: begin
        store_done = 1'b1; @(negedge clk); store_done = 1'b0;
        after_flush("R6 store", exp_addr);
      end
      default: begin
        ctl_flush_wr = 1'b1; @(negedge clk); ctl_flush_wr = 1'b0;
        chk("R7 bit set", 32'(ctl_flush_bit), 32'd1);
        @(negedge clk);
        chk("R7 bit cleared", 32'(ctl_flush_bit), 32'd0);
        after_flush("R7 sw flush", exp_addr);
        pop_one("R7 resume");
      end
    endcase
  endtask

  initial begin
    fetch_ack = 1'b1; instr_pop = 1'b0;
    sp_wr = 1'b0; sp_wdata = '0; xfer_done = 1'b0; xfer_hit = 1'b0; xfer_target = '0;
    store_done = 1'b0; store_noflush = 1'b0; ctl_flush_wr = 1'b0;
    exp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", 32'(instr_valid), 32'd0);
    chk("R1 refetch", 32'(refetch), 32'd0);
    chk("R1 swbit", 32'(ctl_flush_bit), 32'd0);

    for (int v = 0; v < NV; v++) run_op(TBL[v][34:32], TBL[v][31:0]);

    // R3: fill, confirm request stops, then drain 8 back to back
    repeat (20) @(negedge clk);
    chk("R3 full req", 32'(fetch_req), 32'd0);
    for (int i = 0; i < 8; i++) begin
      chk("R3 burst valid", 32'(instr_valid), 32'd1);
      chk("R3 burst data", instr_data, memval(exp_addr));
      instr_pop = 1'b1; @(negedge clk); exp_addr = exp_addr + 4;
    end
    instr_pop = 1'b0;

    // R8: three causes together, script pointer wins
    sp_wr = 1'b1; sp_wdata = 32'h0000_4000;
    xfer_done = 1'b1; xfer_hit = 1'b1; xfer_target = 32'h0000_5000;
    store_done = 1'b1;
    @(negedge clk);
    sp_wr = 1'b0; xfer_done = 1'b0; xfer_hit = 1'b0; store_done = 1'b0;
    after_flush("R8 merge sp", 32'h0000_4000);

    // R10: pop on empty is ignored
    sp_wr = 1'b1; sp_wdata = 32'h0000_6000; @(negedge clk); sp_wr = 1'b0;
    exp_addr = 32'h0000_6000;
    chk("R10 empty", 32'(instr_valid), 32'd0);
    instr_pop = 1'b1; @(negedge clk); instr_pop = 1'b0;
    pop_one("R10 first after stall");

    // R8: transfer beats store; R9 stale responses dropped
    xfer_done = 1'b1; xfer_hit = 1'b1; xfer_target = 32'h0000_7100; store_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0; xfer_hit = 1'b0; store_done = 1'b0;
    after_flush("R8 merge xfer", 32'h0000_7100);
    for (int i = 0; i < 4; i++) pop_one("R9 stale dropped");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule